// File: doc/BRIEF.md
# Table-Driven I2C Register Initialisation Sequencer

After reset, this block works through a constant list of 17-bit command words, one entry at a time and in index order. Each word holds one of two kinds of command. The first kind is a local action: set the level of a reset pin that goes to an external device, load the I2C address byte used by later writes, or pause for a set number of time units. The second kind is a register write. For a write, the sequencer hands the address byte, a register number and a data byte to a separate byte-level I2C write engine, then waits until that engine reports the transfer as finished.

Because each entry completes fully before the next one is fetched, a single table can hold a whole bring-up sequence. Reset pulses and settling pauses can sit between register writes. If the engine reports a missing acknowledge, a sticky error flag is set and the sequence keeps going. When the last entry is finished, a done flag rises. The block then stays idle until the next reset.

Top module: `i2c_init_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs take these values: `dev_rst_o` = `RST_OUT_INIT` (default 0), `wr_req_o` = 0, `done_o` = 0, `err_o` = 0, and the address byte = `ADDR_INIT` (default 0x00). The first cycle after release fetches entry 0.
- R2: Entries run strictly in index order, and each one finishes before the next is fetched. Reset-pin, address-load and no-op entries take exactly one cycle each.
- R3: A word with bit 16 = 0 is a register write, with `wr_reg_o` = bits 15:8 and `wr_data_o` = bits 7:0. This holds even when bits 15:8 equal an opcode value. `wr_addr_o` carries the most recently loaded address byte. `wr_req_o` rises in the cycle after the fetch and stays high, with stable fields, until `wr_busy_i` is seen high.
- R4: A write ends in the first cycle in which `wr_busy_i` is low after it was seen high. The next entry is fetched in the following cycle. An engine that holds busy for H+1 cycles therefore makes the write entry last H+3 cycles.
- R5: A word with bit 16 = 1 and bits 15:8 = 0x01 drives `dev_rst_o` to bit 0. The new level appears in the cycle after the fetch.
- R6: A word with bit 16 = 1 and bits 15:8 = 0x00 latches bits 7:0 as the address byte. Every later write uses that byte until another address load replaces it.
- R7: A word with bit 16 = 1 and bits 15:8 = 0x02 pauses for bits 7:0 × TICK cycles, where TICK = `CLK_KHZ`·`TICK_US`/1000. The entry therefore lasts 1 + n·TICK cycles. A count of zero gives a one-cycle entry.
- R8: A word with bit 16 = 1 and any other value in bits 15:8 is a one-cycle no-op. It changes neither `dev_rst_o` nor the address byte.
- R9: If `wr_nack_i` is high in the cycle that ends a write, `err_o` rises in the next cycle. It then stays high until reset, and the sequence carries on.
- R10: `done_o` rises in the cycle after the last entry completes. From then until reset it stays high, no request is issued and `dev_rst_o` holds.
- R11: Asserting `rst_ni` in the middle of a sequence, or after it has finished, returns the block to the R1 state. The sequence then restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_rst_o | output | 1 | Reset pin driven to the external device |
| wr_req_o | output | 1 | Write request to the I2C byte engine |
| wr_addr_o | output | 8 | Address byte for the write (7-bit address plus R/W bit) |
| wr_reg_o | output | 8 | Register number for the write |
| wr_data_o | output | 8 | Data byte for the write |
| wr_busy_i | input | 1 | Engine busy with the current transfer |
| wr_nack_i | input | 1 | Engine saw no acknowledge; valid in the cycle busy falls |
| done_o | output | 1 | All table entries have been executed |
| err_o | output | 1 | Sticky flag: at least one write was not acknowledged |

## Verification
The bench runs one table that uses every opcode, under several engine busy lengths and acknowledge-failure patterns. It predicts the exact cycle of every request, reset-pin edge, error rise and done rise from a cost model of the entries.

The table includes writes whose register number matches an opcode value. A decoder that ignores bit 16 would turn these into local actions, and a write would go missing. It also includes a zero-length delay, which a design that wrapped the unit counter would turn into a 256-unit pause that shows up as late requests. A no-op with bit 0 set must leave the reset pin alone, and an address reload must redirect the writes that follow.

Further cases cover a failure on the last write, to catch a flag that is set late or cleared. A reset in the middle of a sequence must restore the initial pin level, and no request may follow the done flag.

// File: rtl/i2c_init_pkg.sv
package i2c_init_pkg;

  localparam int unsigned CMD_W = 17;

  localparam logic [7:0] SUB_ADDR  = 8'h00;
  localparam logic [7:0] SUB_RST   = 8'h01;
  localparam logic [7:0] SUB_DELAY = 8'h02;

  typedef enum logic [2:0] {
    OP_WRITE,
    OP_ADDR,
    OP_RST,
    OP_DELAY,
    OP_NOP
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] hi;
    logic [7:0] lo;
  } cmd_t;

  typedef enum logic [2:0] {
    S_FETCH,
    S_ISSUE,
    S_WAIT,
    S_DELAY,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/i2c_init_decode.sv
module i2c_init_decode
  import i2c_init_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_t             cmd_o
);

  always_comb begin
    cmd_o.hi = word_i[15:8];
    cmd_o.lo = word_i[7:0];
    if (!word_i[16]) begin
      cmd_o.op = OP_WRITE;
    end else begin
      unique case (word_i[15:8])
        SUB_ADDR:  cmd_o.op = OP_ADDR;
        SUB_RST:   cmd_o.op = OP_RST;
        SUB_DELAY: cmd_o.op = OP_DELAY;
        default:   cmd_o.op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/i2c_init_delay.sv
module i2c_init_delay #(
  parameter int unsigned TICK_CYCLES = 25000,
  parameter int unsigned UNIT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [UNIT_W-1:0] units_i,
  output logic              expire_o
);

  logic              run_q;
  logic [UNIT_W-1:0] unit_q;
  logic              tick_last;

  // tick prescaler only exists when a unit spans more than one cycle
  generate
    if (TICK_CYCLES > 1) begin : g_tick
      localparam int unsigned TICK_W = $clog2(TICK_CYCLES);
      logic [TICK_W-1:0] tick_q;

      assign tick_last = (tick_q == TICK_W'(TICK_CYCLES - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tick_q <= '0;
        end else if (start_i || tick_last) begin
          tick_q <= '0;
        end else if (run_q) begin
          tick_q <= tick_q + TICK_W'(1);
        end
      end
    end else begin : g_no_tick
      assign tick_last = 1'b1;
    end
  endgenerate

  assign expire_o = run_q && tick_last && (unit_q == UNIT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      unit_q <= '0;
    end else if (start_i) begin
      run_q  <= (units_i != '0);
      unit_q <= units_i;
    end else if (run_q && tick_last) begin
      if (unit_q == UNIT_W'(1)) run_q <= 1'b0;
      unit_q <= unit_q - UNIT_W'(1);
    end
  end

endmodule

// File: rtl/i2c_init_fsm.sv
module i2c_init_fsm
  import i2c_init_pkg::*;
#(
  parameter int unsigned TABLE_LEN    = 14,
  parameter logic        RST_OUT_INIT = 1'b0,
  parameter logic [7:0]  ADDR_INIT    = 8'h00,
  localparam int unsigned IDX_W       = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             dly_start_o,
  input  logic             dly_expire_i,
  output logic             dev_rst_o,
  output logic             wr_req_o,
  output logic [7:0]       wr_addr_o,
  output logic [7:0]       wr_reg_o,
  output logic [7:0]       wr_data_o,
  input  logic             wr_busy_i,
  input  logic             wr_nack_i,
  output logic             done_o,
  output logic             err_o
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             in_fetch;
  logic             local_step;
  logic             step;
  logic             last;

  assign in_fetch   = (state_q == S_FETCH);
  assign local_step = in_fetch &&
                      ((cmd_i.op == OP_ADDR) || (cmd_i.op == OP_RST) ||
                       (cmd_i.op == OP_NOP) ||
                       ((cmd_i.op == OP_DELAY) && (cmd_i.lo == 8'h00)));
  assign step       = local_step ||
                      ((state_q == S_WAIT) && !wr_busy_i) ||
                      ((state_q == S_DELAY) && dly_expire_i);
  assign last       = (idx_q == IDX_W'(TABLE_LEN - 1));

  assign dly_start_o = in_fetch && (cmd_i.op == OP_DELAY);
  assign idx_o       = idx_q;
  assign wr_req_o    = (state_q == S_ISSUE);
  assign done_o      = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      idx_q   <= '0;
    end else if (step) begin
      if (last) begin
        state_q <= S_DONE;
      end else begin
        idx_q   <= idx_q + IDX_W'(1);
        state_q <= S_FETCH;
      end
    end else begin
      unique case (state_q)
        S_FETCH: begin
          if (cmd_i.op == OP_WRITE)      state_q <= S_ISSUE;
          else if (cmd_i.op == OP_DELAY) state_q <= S_DELAY;
        end
        S_ISSUE: if (wr_busy_i) state_q <= S_WAIT;
        default: ;
      endcase
    end
  end

  // side effects of the fetched word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_rst_o <= RST_OUT_INIT;
      wr_addr_o <= ADDR_INIT;
      wr_reg_o  <= '0;
      wr_data_o <= '0;
    end else if (in_fetch) begin
      unique case (cmd_i.op)
        OP_RST:   dev_rst_o <= cmd_i.lo[0];
        OP_ADDR:  wr_addr_o <= cmd_i.lo;
        OP_WRITE: begin
          wr_reg_o  <= cmd_i.hi;
          wr_data_o <= cmd_i.lo;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
    end else if ((state_q == S_WAIT) && !wr_busy_i && wr_nack_i) begin
      err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_init_seq.sv
module i2c_init_seq
  import i2c_init_pkg::*;
#(
  parameter int unsigned TABLE_LEN = 14,
  parameter logic [CMD_W-1:0] INIT_TABLE [TABLE_LEN] = '{
    17'h1_0100, 17'h1_0210, 17'h1_0101, 17'h1_0205,
    17'h1_0090, 17'h0_1001, 17'h0_1120, 17'h1_0202,
    17'h0_2203, 17'h0_2340, 17'h1_0201, 17'h0_3001,
    17'h0_3180, 17'h0_0F01
  },
  parameter int unsigned CLK_KHZ      = 25000,
  parameter int unsigned TICK_US      = 1000,
  parameter logic        RST_OUT_INIT = 1'b0,
  parameter logic [7:0]  ADDR_INIT    = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       dev_rst_o,
  output logic       wr_req_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_reg_o,
  output logic [7:0] wr_data_o,
  input  logic       wr_busy_i,
  input  logic       wr_nack_i,
  output logic       done_o,
  output logic       err_o
);

  localparam int unsigned IDX_W     = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1;
  localparam int unsigned TICK_RAW  = (CLK_KHZ * TICK_US) / 1000;
  localparam int unsigned TICK_CYC  = (TICK_RAW > 0) ? TICK_RAW : 1;

  logic [IDX_W-1:0] idx;
  logic [CMD_W-1:0] word;
  cmd_t             cmd;
  logic             dly_start;
  logic             dly_expire;

  // table read as a compare-select over the entries
  always_comb begin
    word = '0;
    for (int i = 0; i < TABLE_LEN; i++) begin
      if (idx == IDX_W'(i)) word = INIT_TABLE[i];
    end
  end

  i2c_init_decode u_dec (
    .word_i (word),
    .cmd_o  (cmd)
  );

  i2c_init_delay #(
    .TICK_CYCLES (TICK_CYC),
    .UNIT_W      (8)
  ) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (dly_start),
    .units_i  (cmd.lo),
    .expire_o (dly_expire)
  );

  i2c_init_fsm #(
    .TABLE_LEN    (TABLE_LEN),
    .RST_OUT_INIT (RST_OUT_INIT),
    .ADDR_INIT    (ADDR_INIT)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .idx_o        (idx),
    .dly_start_o  (dly_start),
    .dly_expire_i (dly_expire),
    .dev_rst_o    (dev_rst_o),
    .wr_req_o     (wr_req_o),
    .wr_addr_o    (wr_addr_o),
    .wr_reg_o     (wr_reg_o),
    .wr_data_o    (wr_data_o),
    .wr_busy_i    (wr_busy_i),
    .wr_nack_i    (wr_nack_i),
    .done_o       (done_o),
    .err_o        (err_o)
  );

endmodule

// File: rtl/i2c_init_seq_chk.sv
module i2c_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dev_rst_o,
  input logic       wr_req_o,
  input logic [7:0] wr_addr_o,
  input logic [7:0] wr_reg_o,
  input logic [7:0] wr_data_o,
  input logic       wr_busy_i,
  input logic       wr_nack_i,
  input logic       done_o,
  input logic       err_o
);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_busy_i) |=> wr_req_o); // R3

  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_busy_i) |=>
      ($stable(wr_addr_o) && $stable(wr_reg_o) && $stable(wr_data_o))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(wr_nack_i && !wr_busy_i)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(dev_rst_o))); // R10

  AST_NO_REQ_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_req_o); // R10

  AST_DONE_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(wr_busy_i)); // R4

  AST_ONE_CMD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_o) |-> !wr_req_o); // R2

endmodule

bind i2c_init_seq i2c_init_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dev_rst_o (dev_rst_o),
  .wr_req_o  (wr_req_o),
  .wr_addr_o (wr_addr_o),
  .wr_reg_o  (wr_reg_o),
  .wr_data_o (wr_data_o),
  .wr_busy_i (wr_busy_i),
  .wr_nack_i (wr_nack_i),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/sim_i2c_init_seq.sv
module sim_i2c_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 14;
  localparam int TICK       = 4;   // CLK_KHZ=4, TICK_US=1000
  localparam logic [16:0] TBL [N] = '{
    17'h1_0101, 17'h1_0100, 17'h1_0101, 17'h1_008A,
    17'h0_8000, 17'h1_0203, 17'h0_0102, 17'h1_0300,
    17'h1_0200, 17'h1_0054, 17'h0_86FF, 17'h1_FF01,
    17'h1_0100, 17'h0_0200
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_rst, req, done, err;
  logic [7:0] addr, rg, dat;
  logic       busy = 1'b0;
  logic       nack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_init_seq #(
    .TABLE_LEN  (N),
    .INIT_TABLE (TBL),
    .CLK_KHZ    (4),
    .TICK_US    (1000)
  ) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dev_rst_o (dev_rst),
    .wr_req_o  (req),
    .wr_addr_o (addr),
    .wr_reg_o  (rg),
    .wr_data_o (dat),
    .wr_busy_i (busy),
    .wr_nack_i (nack),
    .done_o    (done),
    .err_o     (err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected event model
  int exp_wc[8]; int exp_wa[8]; int exp_wr[8]; int exp_wd[8]; int nw;
  int exp_rc[8]; int exp_rv[8]; int nr;
  int exp_done; int exp_err;

  task automatic model(input int h, input int pat);
    int s = 0; int a = 0; int rv = 0;
    nw = 0; nr = 0; exp_err = -1;
    for (int e = 0; e < N; e++) begin
      logic [16:0] w = TBL[e];
      if (!w[16]) begin
        exp_wc[nw] = s + 1; exp_wa[nw] = a;
        exp_wr[nw] = int'(w[15:8]); exp_wd[nw] = int'(w[7:0]);
        if (pat[nw] && exp_err < 0) exp_err = s + h + 3;
        nw++;
        s += h + 3;
      end else if (w[15:8] == 8'h01) begin
        if (int'(w[0]) != rv) begin
          exp_rc[nr] = s + 1; exp_rv[nr] = int'(w[0]); nr++;
        end
        rv = int'(w[0]);
        s += 1;
      end else if (w[15:8] == 8'h00) begin
        a = int'(w[7:0]); s += 1;
      end else if (w[15:8] == 8'h02) begin
        s += 1 + int'(w[7:0]) * TICK;
      end else begin
        s += 1;
      end
    end
    exp_done = s;
  endtask

  task automatic run_pass(input int h, input int pat, input int abort_at);
    int wi = 0; int ri = 0; int hold = 0; int cur = 0;
    bit done_seen = 0; bit err_seen = 0; logic prev_rst;
    model(h, pat);
    @(negedge clk);
    rst_n = 1'b0; busy = 1'b0; nack = 1'b0;
    @(negedge clk);
    chk(dev_rst == 1'b0, "R1", "reset dev_rst", int'(dev_rst), 0);
    chk(req == 1'b0, "R1", "reset req", int'(req), 0);
    chk(done == 1'b0 && err == 1'b0, "R11", "reset done/err", int'({done, err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_rst = dev_rst;
    for (int cyc = 0; cyc <= exp_done + 40; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (dev_rst !== prev_rst) begin
        if (ri < nr) begin
          chk(cyc == exp_rc[ri], "R5", "rst edge cycle", cyc, exp_rc[ri]);
          chk(int'(dev_rst) == exp_rv[ri], "R5", "rst level", int'(dev_rst), exp_rv[ri]);
        end else chk(0, "R8", "unexpected rst change", cyc, -1);
        ri++;
        prev_rst = dev_rst;
      end
      if (done && !done_seen) begin
        chk(cyc == exp_done, "R10", "done cycle", cyc, exp_done);
        done_seen = 1;
      end else if (done_seen && (!done || req)) begin
        chk(0, "R10", "done/idle after done", int'({done, req}), 2);
      end
      if (err && !err_seen) begin
        chk(cyc == exp_err, "R9", "err rise cycle", cyc, exp_err);
        err_seen = 1;
      end else if (err_seen && !err) begin
        chk(0, "R9", "err not sticky", 0, 1);
      end
      // engine model
      if (busy) begin
        if (hold == 0) begin busy = 1'b0; nack = pat[cur]; end
        else hold--;
      end else begin
        nack = 1'b0;
        if (req) begin
          if (wi < nw) begin
            chk(cyc == exp_wc[wi], "R4", "write request cycle", cyc, exp_wc[wi]);
            chk(int'(addr) == exp_wa[wi], "R6", "write addr", int'(addr), exp_wa[wi]);
            chk(int'(rg) == exp_wr[wi] && int'(dat) == exp_wd[wi], "R3",
                "write reg/data", int'({rg, dat}), (exp_wr[wi] << 8) | exp_wd[wi]);
          end else chk(0, "R2", "extra write", wi, nw);
          cur = wi; wi++;
          busy = 1'b1; hold = h;
        end
      end
      if (abort_at > 0 && cyc == abort_at) return;
    end
    chk(wi == nw, "R2", "write count", wi, nw);
    chk(ri == nr, "R7", "rst edge count", ri, nr);
    chk(done_seen, "R10", "done seen", int'(done_seen), 1);
    chk(err_seen == (exp_err >= 0), "R9", "err final", int'(err_seen), int'(exp_err >= 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_pass(0, 0, 0);
    run_pass(2, 4'b0010, 3);   // abort with dev_rst high, R11
    run_pass(1, 4'b0010, 0);
    run_pass(3, 4'b1000, 0);
    run_pass(7, 4'b0101, 0);
    run_pass(0, 4'b1111, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule